// File: doc/BRIEF.md
# Left-justified to parallel-burst DAC format converter

This block sits between a digital audio receiver that emits a left-justified serial stream and a multibit DAC that takes both channels at once. It runs on a fast system clock. The incoming bit clock, word clock and serial data are oversampled through a synchronizer. Each channel slot is 32 bit clocks long, so a stereo frame is 64 bit clocks. The block keeps the first 16 bits of each slot and discards the rest.

Once a frame has closed cleanly, both captured words are shifted out side by side in the next frame. They go out on two data lines that share one gated bit clock, as a 16-clock burst with the top bit of each word flipped. A quiet stretch of 48 bit periods follows the burst. The clock and both data lines stay low during that stretch. Inside it, a separate latch strobe tells the DAC to transfer the words once switching activity has died down.

The data path is a fixed-rate serial stream and the DAC has no way to stall it. There is therefore no valid/ready handshake and no back-pressure at the block's edge. Between the capture and emit stages, a single-cycle valid pulse hands over one word pair per frame, and the emitter always accepts it. Slot-length faults raise an error flag and drop the frame.

Top module: `pcm_par_burst`

## Requirements
- R1: The input word clock high marks the left slot and low marks the right slot. Serial data is sampled on rising input bit clock edges. The first rising edge after a word clock transition carries the MSB, and the following bits come MSB first.
- R2: Left and right output bits are presented together on dl_o and dr_o. Both lines change only while bclk_o falls, and both are stable at every rising edge of bclk_o.
- R3: Each accepted frame yields exactly 16 rising edges of bclk_o. The bits sampled there are the captured 16-bit word with bit 15 (sent first) inverted and bits 14..0 unchanged.
- R4: Input bits 16 to 31 of a slot have no effect on the output words.
- R5: A frame's burst starts on the first falling input bit clock after the word clock rise that ends that frame. The first bclk_o rise follows the second input bit clock rise counted from that word clock rise, which gives one frame of latency.
- R6: After the 16th data bit, bclk_o stays low and dl_o and dr_o stay 0 for the remaining 48 bit periods of the frame.
- R7: le_o rises on the input bit clock fall that comes 32 bit periods after the burst ends. It stays high for exactly one bit period, and never while bclk_o is high.
- R8: A slot that is not 32 bit clocks long sets err_o and drops its frame: no burst and no latch. The first word clock edge after reset is exempt. err_o clears when a later frame closes with both slots correct.
- R9: While reset is asserted, bclk_o, dl_o, dr_o, le_o and err_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the input bit clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Input serial bit clock |
| wclk_i | input | 1 | Input word clock, high for left slot |
| sdat_i | input | 1 | Input serial data, left-justified |
| bclk_o | output | 1 | Gated bit clock shared by both output lines |
| dl_o | output | 1 | Left channel output data |
| dr_o | output | 1 | Right channel output data |
| le_o | output | 1 | Latch strobe, one bit period wide |
| err_o | output | 1 | Slot-length fault flag |

## Verification
The word pairs cover several cases. All-zero and all-one words, and words that differ only in the top bit, show whether the flip touches only bit 15. Alternating and asymmetric patterns show whether the two channels are swapped or bit-reversed. The unused tail of every slot carries toggling filler, so a capture that runs past 16 bits corrupts the comparison. A short left slot and a long right slot each have to drop exactly one frame and set the flag, and the following good frames show that the flag clears and that the burst and latch spacing stay locked to the word clock.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  // Emitter phase within one output frame
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_QUIET = 2'd2
  } emit_phase_e;
endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdat_i,
  output logic bclk_s,
  output logic wclk_s,
  output logic sdat_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sb, sw, sd;
  logic bprev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb    <= '0;
      sw    <= '0;
      sd    <= '0;
      bprev <= 1'b0;
    end else begin
      sb    <= {sb[STAGES-2:0], bclk_i};
      sw    <= {sw[STAGES-2:0], wclk_i};
      sd    <= {sd[STAGES-2:0], sdat_i};
      bprev <= sb[STAGES-1];
    end
  end

  assign bclk_s = sb[STAGES-1];
  assign wclk_s = sw[STAGES-1];
  assign sdat_s = sd[STAGES-1];
  assign rise   = bclk_s & ~bprev;
  assign fall   = ~bclk_s & bprev;
endmodule

// File: rtl/pbc_capture.sv
module pbc_capture #(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              wclk_s,
  input  logic              sdat_s,
  output logic              vld,
  output logic [WORD_W-1:0] lword,
  output logic [WORD_W-1:0] rword,
  output logic              err
);
  localparam int CW = $clog2(SLOT_W + 2) + 1;
  localparam logic [CW-1:0] CMAX  = CW'(SLOT_W + 1);
  localparam logic [CW-1:0] CSLOT = CW'(SLOT_W);
  localparam logic [CW-1:0] CWORD = CW'(WORD_W);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh;
  logic              primed, seen, wprev, l_ok;
  logic              slot_ok;

  assign slot_ok = (cnt == CSLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      primed <= 1'b0;
      seen   <= 1'b0;
      wprev  <= 1'b0;
      l_ok   <= 1'b0;
      vld    <= 1'b0;
      lword  <= '0;
      rword  <= '0;
      err    <= 1'b0;
    end else begin
      vld <= 1'b0;
      if (rise) begin
        primed <= 1'b1;
        wprev  <= wclk_s;
        if (primed && (wclk_s != wprev)) begin
          if (wclk_s) begin
            // right slot ends, frame closes
            rword <= sh;
            if (seen && !slot_ok) err <= 1'b1;
            if (l_ok && slot_ok) begin
              vld <= 1'b1;
              err <= 1'b0;
            end
            l_ok <= 1'b0;
          end else begin
            // left slot ends
            lword <= sh;
            l_ok  <= seen && slot_ok;
            if (seen && !slot_ok) err <= 1'b1;
          end
          seen <= 1'b1;
          cnt  <= CW'(1);
          sh   <= {sh[WORD_W-2:0], sdat_s};
        end else begin
          if (cnt < CWORD) sh <= {sh[WORD_W-2:0], sdat_s};
          if (cnt != CMAX) cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pbc_emit.sv
module pbc_emit
  import pbc_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int FRAME_BITS = 64,
  parameter int LATCH_AT   = 48,
  parameter int LATCH_LEN  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_s,
  input  logic              fall,
  input  logic              vld,
  input  logic [WORD_W-1:0] lword,
  input  logic [WORD_W-1:0] rword,
  output logic              bclk_o,
  output logic              dl_o,
  output logic              dr_o,
  output logic              le_o
);
  localparam int PW = $clog2(FRAME_BITS) + 1;
  localparam logic [PW-1:0] P_WORD  = PW'(WORD_W);
  localparam logic [PW-1:0] P_LAST  = PW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] P_LE_ON = PW'(LATCH_AT);
  localparam logic [PW-1:0] P_LE_OF = PW'(LATCH_AT + LATCH_LEN);

  emit_phase_e       ph;
  logic              pend, gate;
  logic [WORD_W-1:0] stg_l, stg_r, shl, shr;
  logic [PW-1:0]     pos, nxt;

  assign nxt = pos + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      pend   <= 1'b0;
      gate   <= 1'b0;
      stg_l  <= '0;
      stg_r  <= '0;
      shl    <= '0;
      shr    <= '0;
      pos    <= '0;
      bclk_o <= 1'b0;
      dl_o   <= 1'b0;
      dr_o   <= 1'b0;
      le_o   <= 1'b0;
    end else begin
      bclk_o <= bclk_s & gate;
      if (vld) begin
        pend  <= 1'b1;
        stg_l <= {~lword[WORD_W-1], lword[WORD_W-2:0]};
        stg_r <= {~rword[WORD_W-1], rword[WORD_W-2:0]};
      end
      if (fall) begin
        if (pend) begin
          pend <= 1'b0;
          ph   <= PH_SHIFT;
          pos  <= '0;
          gate <= 1'b1;
          le_o <= 1'b0;
          dl_o <= stg_l[WORD_W-1];
          dr_o <= stg_r[WORD_W-1];
          shl  <= {stg_l[WORD_W-2:0], 1'b0};
          shr  <= {stg_r[WORD_W-2:0], 1'b0};
        end else if (ph != PH_IDLE) begin
          pos <= nxt;
          if (nxt < P_WORD) begin
            dl_o <= shl[WORD_W-1];
            dr_o <= shr[WORD_W-1];
            shl  <= {shl[WORD_W-2:0], 1'b0};
            shr  <= {shr[WORD_W-2:0], 1'b0};
          end else if (nxt == P_WORD) begin
            gate <= 1'b0;
            dl_o <= 1'b0;
            dr_o <= 1'b0;
            ph   <= PH_QUIET;
          end
          le_o <= (nxt >= P_LE_ON) && (nxt < P_LE_OF);
          if (pos == P_LAST) ph <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_par_burst.sv
module pcm_par_burst #(
  parameter int WORD_W      = 16,
  parameter int SLOT_W      = 32,
  parameter int LATCH_GAP   = 32,
  parameter int LATCH_LEN   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdat_i,
  output logic bclk_o,
  output logic dl_o,
  output logic dr_o,
  output logic le_o,
  output logic err_o
);
  localparam int FRAME_BITS = 2 * SLOT_W;
  localparam int LATCH_AT   = WORD_W + LATCH_GAP;

  logic bclk_s, wclk_s, sdat_s, b_rise, b_fall;
  logic cap_vld;
  logic [WORD_W-1:0] cap_l, cap_r;

  pbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bclk_i(bclk_i), .wclk_i(wclk_i), .sdat_i(sdat_i),
    .bclk_s(bclk_s), .wclk_s(wclk_s), .sdat_s(sdat_s),
    .rise(b_rise), .fall(b_fall)
  );

  pbc_capture #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .rise(b_rise), .wclk_s(wclk_s), .sdat_s(sdat_s),
    .vld(cap_vld), .lword(cap_l), .rword(cap_r), .err(err_o)
  );

  pbc_emit #(
    .WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS),
    .LATCH_AT(LATCH_AT), .LATCH_LEN(LATCH_LEN)
  ) u_emit (
    .clk(clk), .rst_n(rst_n),
    .bclk_s(bclk_s), .fall(b_fall),
    .vld(cap_vld), .lword(cap_l), .rword(cap_r),
    .bclk_o(bclk_o), .dl_o(dl_o), .dr_o(dr_o), .le_o(le_o)
  );
endmodule

// File: rtl/pcm_par_burst_chk.sv
module pcm_par_burst_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_o,
  input logic dl_o,
  input logic dr_o,
  input logic le_o,
  input logic err_o,
  input logic cap_vld
);
  a_r7_latch_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> !bclk_o);

  a_r6_latch_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    le_o |-> (!dl_o && !dr_o));

  a_r2_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_o) |-> ($stable(dl_o) && $stable(dr_o)));

  a_r8_accept_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> !err_o);

  a_r5_one_handover: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> !cap_vld);
endmodule

bind pcm_par_burst pcm_par_burst_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .dl_o(dl_o), .dr_o(dr_o),
  .le_o(le_o), .err_o(err_o), .cap_vld(cap_vld)
);

// File: tb/pcm_par_burst_tb_top.sv
`timescale 1ns/1ps
module pcm_par_burst_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, sdat = 1'b0;
  logic bclk_o, dl_o, dr_o, le_o, err_o;

  always #2.5 clk = ~clk;

  pcm_par_burst dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdat_i(sdat),
    .bclk_o(bclk_o), .dl_o(dl_o), .dr_o(dr_o), .le_o(le_o), .err_o(err_o)
  );

  int n_tests = 0, n_fail = 0;
  bit mon_on = 1'b0, done = 1'b0;
  logic [31:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor
  int rises = 0, wrise_at = 0, last_out = 0, le_start = 0, nbit = 0;
  logic [15:0] accl = '0, accr = '0;
  always @(posedge bclk) rises++;
  always @(posedge wclk) wrise_at = rises;

  always @(posedge bclk_o) if (mon_on) begin
    if (nbit == 0)
      chk(rises - wrise_at == 2, "R5", "burst start offset", rises - wrise_at, 2);
    accl = {accl[14:0], dl_o};
    accr = {accr[14:0], dr_o};
    nbit++;
    last_out = rises;
    if (nbit == 16) begin
      nbit = 0;
      if (expq.size() == 0) chk(0, "R8", "unexpected burst", {accl, accr}, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk({accl, accr} == e, "R3", "burst words L/R", {accl, accr}, e);
      end
    end
  end

  always @(posedge le_o) if (mon_on) begin
    chk(rises - last_out == 32, "R7", "latch delay", rises - last_out, 32);
    chk({bclk_o, dl_o, dr_o} == 3'b000, "R6", "quiet at latch", {bclk_o, dl_o, dr_o}, 0);
    chk(nbit == 0, "R3", "bits per burst at latch", nbit, 0);
    le_start = rises;
  end

  always @(negedge le_o) if (mon_on)
    chk(rises - le_start == 1, "R7", "latch width", rises - le_start, 1);

  // driver
  task automatic bit_out(input logic wc, input logic d);
    bclk = 1'b0; wclk = wc; sdat = d;
    #40;
    bclk = 1'b1;
    #40;
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int nl, input int nr, input bit push, input int err_exp);
    for (int k = 0; k < nl; k++) begin
      bit_out(1'b1, (k < 16) ? l[15-k] : k[0]);   // R4: filler after bit 15
      if (k == 2 && err_exp >= 0)
        chk(err_o == err_exp[0], "R8", "error flag", err_o, err_exp);
    end
    for (int k = 0; k < nr; k++)
      bit_out(1'b0, (k < 16) ? r[15-k] : ~k[0]);
    if (push) expq.push_back({l ^ 16'h8000, r ^ 16'h8000});
  endtask

  initial begin
    #100;
    chk({bclk_o, dl_o, dr_o, le_o, err_o} == 5'b0, "R9", "reset outputs",
        {bclk_o, dl_o, dr_o, le_o, err_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int k = 0; k < 8; k++) bit_out(1'b0, 1'b0);
    send_frame(16'h0000, 16'h0000, 32, 32, 1, -1);  // R1 R3
    send_frame(16'hFFFF, 16'h8000, 32, 32, 1, 0);   // R8 first edge exempt
    send_frame(16'h1234, 16'hABCD, 32, 32, 1, -1);
    send_frame(16'h7FFF, 16'h0001, 32, 32, 1, -1);
    send_frame(16'hA5A5, 16'h5A5A, 32, 32, 1, -1);
    send_frame(16'h1111, 16'h2222, 30, 32, 0, -1);  // R8 short left
    send_frame(16'h0F0F, 16'hF0F0, 32, 32, 1, 1);
    send_frame(16'hC3C3, 16'h3C3C, 32, 32, 1, 0);   // R8 cleared
    send_frame(16'h5555, 16'hAAAA, 32, 34, 0, -1);  // R8 long right
    send_frame(16'h8001, 16'h7FFE, 32, 32, 1, 1);
    send_frame(16'h6DB6, 16'h4924, 32, 32, 1, 0);
    send_frame(16'h0000, 16'h0000, 32, 24, 0, -1);  // trailing, never closes
    #200;
    chk(expq.size() == 0, "R3", "bursts outstanding", expq.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule